// File: doc/BRIEF.md
# Indirectly Configured GPIO Port Bank

This block drives and samples a bank of 29 general-purpose pins. The pins are packed into 8-bit ports: port 0 holds pins 0 to 7, port 1 holds pins 8 to 15, port 2 holds pins 16 to 23, and port 3 holds pins 24 to 28. Software moves pin values through a small byte-wide register bus that has an address, write data, and read and write strobes. Each port has one data register. Writing it sets the output latches of every pin in that port at once. Reading it returns a byte built pin by pin. To change a single pin, software reads the register, modifies the bit and writes it back.

Per-pin settings are reached through a separate, indirect path that is forwarded from a configuration space. A select strobe stores a pin code. A configuration strobe then writes a 3-bit setting into the pin that the code names, and a combinational read port shows that pin's current setting. The bank turns each pin's setting and output latch into four pad-control signals: the driven value, the drive enable, the push-pull choice and the pull-up enable.

Top module: `gpio_bank`

## Requirements
- R1: After reset all configuration settings, output latches and bus read data are zero. As a result pad_oe, pad_pp, pad_pu and pad_out are all zero, and cfg_rdata for the default select code 0x00 (pin 0) is zero.
- R2: A select code has the form (port << 4) | bit. Bit 3 must be clear and the pin is port*8+bit. A configuration write stores cfg_wdata[2:0] into that pin: bit 0 enables drive, bit 1 selects push-pull (0 selects open-drain) and bit 2 enables the pull-up. cfg_rdata returns the stored setting in bits 2:0 in the cycle after the write.
- R3: Configuration bits 7:3 always read as zero and are not stored.
- R4: A select code whose bit 7 or bit 3 is set, or that names a pin above 28, makes cfg_rdata read zero. Configuration writes made under such a code change no pin: the pad outputs of all pins stay as they were.
- R5: The select and configuration strobes share cfg_wdata. When both strobes are asserted in the same cycle, the configuration write goes to the pin selected before that cycle, and the new select code applies from the next cycle on.
- R6: The port data registers sit at bus addresses 0x0 (port 0), 0x4 (port 1), 0x8 (port 2) and 0xA (port 3). Reads of any other address return zero. Writes to any other address change no output latch.
- R7: A bus write to a port address loads all eight data bits into the output latches of that port. The new values appear on pad_out in the cycle after the write.
- R8: In a port read, each bit returns the pin's output latch when that pin's drive-enable bit is set. When drive enable is clear, the bit returns pad_in.
- R9: pad_oe for a pin is set only when its drive-enable bit is set and, in addition, either push-pull is selected or the output latch is 0. An open-drain pin whose latch is 1 is released. pad_pp and pad_pu mirror configuration bits 1 and 2.
- R10: Bits 7:5 of the port 3 register read as zero and have no latch behind them.
- R11: bus_rdata is registered. It takes the addressed value at the clock edge where bus_rd is high and holds that value while bus_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 4 | Register bus address |
| bus_wdata | input | 8 | Register bus write data |
| bus_wr | input | 1 | Register bus write strobe |
| bus_rd | input | 1 | Register bus read strobe |
| bus_rdata | output | 8 | Registered read data |
| cfg_sel_wr | input | 1 | Stores cfg_wdata as the pin select code |
| cfg_conf_wr | input | 1 | Writes cfg_wdata[2:0] into the selected pin's settings |
| cfg_wdata | input | 8 | Shared data for select and configuration writes |
| cfg_rdata | output | 8 | Settings of the currently selected pin |
| pad_in | input | 29 | Sampled pin levels |
| pad_out | output | 29 | Output value per pin |
| pad_oe | output | 29 | Drive enable per pin |
| pad_pp | output | 29 | Push-pull (1) or open-drain (0) per pin |
| pad_pu | output | 29 | Pull-up enable per pin |

## Verification
The select and configuration strobes can arrive in the same cycle with one data byte. The bench provokes this by choosing one pin and then pulsing both strobes with a code that names a different pin. It then reads back both pins and judges the result: the old pin must hold the new setting and the new pin must be untouched. A bus data write and a configuration change can also meet on the same pin's pad_oe. The bench sweeps every pin through all eight settings and both latch values, and compares all pad vectors against a model computed in the bench.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int unsigned BUS_AW = 4;
  localparam int unsigned BYTE_W = 8;

  // Per-pin settings; bit 0 is drive enable, bit 1 push-pull, bit 2 pull-up.
  typedef struct packed {
    logic pull_up;
    logic push_pull;
    logic drive_en;
  } pin_cfg_t;

  localparam int unsigned CFG_W = $bits(pin_cfg_t);

  // Maps a bus address to {hit, port[1:0]}; offsets are not evenly spaced.
  function automatic logic [2:0] port_of_addr(input logic [BUS_AW-1:0] a);
    case (a)
      4'h0:    return 3'b100;
      4'h4:    return 3'b101;
      4'h8:    return 3'b110;
      4'hA:    return 3'b111;
      default: return 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/gpio_cfg_store.sv
module gpio_cfg_store
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 29
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sel_wr,
  input  logic                     conf_wr,
  input  logic [BYTE_W-1:0]        wdata,
  output logic [BYTE_W-1:0]        rdata,
  output pin_cfg_t [NUM_PINS-1:0]  cfg
);

  localparam int unsigned PIN_W = $clog2(NUM_PINS);

  logic [BYTE_W-1:0]       sel_q, sel_d;
  pin_cfg_t [NUM_PINS-1:0] cfg_q, cfg_d;
  logic [6:0]              sel_wide;
  logic                    sel_valid;
  logic [PIN_W-1:0]        sel_idx;

  assign sel_wide  = {1'b0, sel_q[6:4], sel_q[2:0]};
  assign sel_valid = !sel_q[7] && !sel_q[3] && (32'(sel_wide) < NUM_PINS);
  assign sel_idx   = sel_wide[PIN_W-1:0];

  always_comb begin
    sel_d = sel_q;
    cfg_d = cfg_q;
    if (sel_wr) sel_d = wdata;
    if (conf_wr && sel_valid) cfg_d[sel_idx] = pin_cfg_t'(wdata[CFG_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      cfg_q <= '0;
    end else begin
      sel_q <= sel_d;
      cfg_q <= cfg_d;
    end
  end

  assign rdata = sel_valid ? {{(BYTE_W-CFG_W){1'b0}}, cfg_q[sel_idx]} : '0;
  assign cfg   = cfg_q;

  // R4: an unmapped select code shields every pin
  a_r4_invalid_sel_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (conf_wr && !sel_valid) |=> $stable(cfg_q));

  // R5: the write lands on the pin selected before the cycle
  a_r5_old_select_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (conf_wr && sel_valid) |=> (cfg_q[$past(sel_idx)] == $past(wdata[CFG_W-1:0])));

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 29
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [BUS_AW-1:0]   addr,
  input  logic [BYTE_W-1:0]   wdata,
  input  logic                wr,
  input  logic                rd,
  input  logic [NUM_PINS-1:0] drive_en,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] out_val,
  output logic [BYTE_W-1:0]   rdata
);

  localparam int unsigned NUM_PORTS = (NUM_PINS + BYTE_W - 1) / BYTE_W;
  localparam int unsigned PAD_W     = NUM_PORTS * BYTE_W;

  logic [2:0]          dec;
  logic                hit;
  logic [1:0]          port;
  logic [NUM_PINS-1:0] out_q, out_d;
  logic [NUM_PINS-1:0] level;
  logic [PAD_W-1:0]    level_pad;
  logic [BYTE_W-1:0]   rd_byte;
  logic [BYTE_W-1:0]   rdata_q, rdata_d;

  assign dec  = port_of_addr(addr);
  assign port = dec[1:0];
  assign hit  = dec[2] && (32'(port) < NUM_PORTS);

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_latch
    assign out_d[i] = (wr && hit && (port == 2'(i / BYTE_W))) ?
                      wdata[i % BYTE_W] : out_q[i];
  end

  assign level     = (drive_en & out_q) | (~drive_en & pad_in);
  assign level_pad = PAD_W'(level);
  assign rd_byte   = hit ? level_pad[port*BYTE_W +: BYTE_W] : '0;

  always_comb begin
    rdata_d = rdata_q;
    if (rd) rdata_d = rd_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q   <= '0;
      rdata_q <= '0;
    end else begin
      out_q   <= out_d;
      rdata_q <= rdata_d;
    end
  end

  assign out_val = out_q;
  assign rdata   = rdata_q;

  // R7: a port 0 write loads the whole byte
  a_r7_port0_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 4'h0) |=> (out_q[BYTE_W-1:0] == $past(wdata)));

  // R11: read data holds without a read strobe
  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata_q));

  // R6: unmapped writes leave every latch alone
  a_r6_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !hit) |=> $stable(out_q));

endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 29
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  pin_cfg_t [NUM_PINS-1:0] cfg,
  input  logic [NUM_PINS-1:0]     out_val,
  output logic [NUM_PINS-1:0]     drive_en,
  output logic [NUM_PINS-1:0]     pad_out,
  output logic [NUM_PINS-1:0]     pad_oe,
  output logic [NUM_PINS-1:0]     pad_pp,
  output logic [NUM_PINS-1:0]     pad_pu
);

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    assign drive_en[i] = cfg[i].drive_en;
    assign pad_pp[i]   = cfg[i].push_pull;
    assign pad_pu[i]   = cfg[i].pull_up;
    assign pad_out[i]  = out_val[i];
    assign pad_oe[i]   = cfg[i].drive_en & (cfg[i].push_pull | ~out_val[i]);

    // R9: open-drain pin with latch 1 is released
    a_r9_od_release: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg[i].push_pull && out_val[i]) |-> !pad_oe[i]);
  end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 29
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [3:0]          bus_addr,
  input  logic [7:0]          bus_wdata,
  input  logic                bus_wr,
  input  logic                bus_rd,
  output logic [7:0]          bus_rdata,
  input  logic                cfg_sel_wr,
  input  logic                cfg_conf_wr,
  input  logic [7:0]          cfg_wdata,
  output logic [7:0]          cfg_rdata,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_PINS-1:0] pad_pp,
  output logic [NUM_PINS-1:0] pad_pu
);

  logic [1:0]              rst_sync;
  logic                    rst_n_int;
  pin_cfg_t [NUM_PINS-1:0] cfg;
  logic [NUM_PINS-1:0]     out_val;
  logic [NUM_PINS-1:0]     drive_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_int = rst_sync[1];

  gpio_cfg_store #(.NUM_PINS(NUM_PINS)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .sel_wr  (cfg_sel_wr),
    .conf_wr (cfg_conf_wr),
    .wdata   (cfg_wdata),
    .rdata   (cfg_rdata),
    .cfg     (cfg)
  );

  gpio_port_regs #(.NUM_PINS(NUM_PINS)) u_ports (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .wr       (bus_wr),
    .rd       (bus_rd),
    .drive_en (drive_en),
    .pad_in   (pad_in),
    .out_val  (out_val),
    .rdata    (bus_rdata)
  );

  gpio_pad_ctl #(.NUM_PINS(NUM_PINS)) u_pads (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .cfg      (cfg),
    .out_val  (out_val),
    .drive_en (drive_en),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe),
    .pad_pp   (pad_pp),
    .pad_pu   (pad_pu)
  );

endmodule

// File: tb/test_gpio_bank.sv
`timescale 1ns/1ps
module test_gpio_bank;

  localparam int NP = 29;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3:0]    bus_addr = '0;
  logic [7:0]    bus_wdata = '0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]    bus_rdata;
  logic          cfg_sel_wr = 1'b0, cfg_conf_wr = 1'b0;
  logic [7:0]    cfg_wdata = '0;
  logic [7:0]    cfg_rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out, pad_oe, pad_pp, pad_pu;

  int n_run = 0, n_fail = 0;

  // bench model
  logic [2:0]    m_cfg [NP];
  logic [NP-1:0] m_out;
  logic [7:0]    m_sel;

  always #4 clk = ~clk;

  gpio_bank i_gpio_bank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .cfg_sel_wr(cfg_sel_wr), .cfg_conf_wr(cfg_conf_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pp(pad_pp), .pad_pu(pad_pu)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  function automatic int sel_pin(input logic [7:0] s);
    int p;
    p = int'(s[6:4]) * 8 + int'(s[2:0]);
    if (s[7] || s[3] || p >= NP) return -1;
    return p;
  endfunction

  function automatic logic [7:0] exp_cfg_rd();
    int p;
    p = sel_pin(m_sel);
    return (p < 0) ? 8'h00 : {5'b0, m_cfg[p]};
  endfunction

  function automatic int port_of(input logic [3:0] a);
    case (a)
      4'h0: return 0;
      4'h4: return 1;
      4'h8: return 2;
      4'hA: return 3;
      default: return -1;
    endcase
  endfunction

  function automatic logic [7:0] exp_bus_rd(input logic [3:0] a);
    logic [7:0] r;
    int p;
    r = '0;
    p = port_of(a);
    if (p >= 0)
      for (int j = 0; j < 8; j++)
        if (p*8 + j < NP)
          r[j] = m_cfg[p*8+j][0] ? m_out[p*8+j] : pad_in[p*8+j];
    return r;
  endfunction

  task automatic chk_pads(input string req);
    logic [NP-1:0] oe, pp, pu;
    for (int i = 0; i < NP; i++) begin
      oe[i] = m_cfg[i][0] & (m_cfg[i][1] | ~m_out[i]);
      pp[i] = m_cfg[i][1];
      pu[i] = m_cfg[i][2];
    end
    chk({req, " pad_oe"}, 32'(pad_oe), 32'(oe));
    chk({req, " pad_pp"}, 32'(pad_pp), 32'(pp));
    chk({req, " pad_pu"}, 32'(pad_pu), 32'(pu));
    chk({req, " pad_out"}, 32'(pad_out), 32'(m_out));
  endtask

  task automatic do_sel(input logic [7:0] v);
    cfg_sel_wr = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_sel_wr = 1'b0;
    m_sel = v;
  endtask

  task automatic do_conf(input logic [7:0] v);
    int p;
    cfg_conf_wr = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_conf_wr = 1'b0;
    p = sel_pin(m_sel);
    if (p >= 0) m_cfg[p] = v[2:0];
  endtask

  task automatic do_bwr(input logic [3:0] a, input logic [7:0] d);
    int p;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    p = port_of(a);
    if (p >= 0)
      for (int j = 0; j < 8; j++)
        if (p*8 + j < NP) m_out[p*8+j] = d[j];
  endtask

  task automatic do_brd(input logic [3:0] a, output logic [7:0] got);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    got = bus_rdata;
  endtask

  task automatic set_pin_cfg(input int p, input logic [2:0] c);
    do_sel(8'(((p / 8) << 4) | (p % 8)));
    do_conf({5'b0, c});
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] got, held;
    logic [NP-1:0] pats [4];
    pats[0] = '0; pats[1] = '1; pats[2] = 29'h0AAA_5555; pats[3] = 29'h1357_9BDF;
    for (int i = 0; i < NP; i++) m_cfg[i] = '0;
    m_out = '0; m_sel = '0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk_pads("R1");
    chk("R1 cfg_rdata", 32'(cfg_rdata), 32'h0);
    chk("R1 bus_rdata", 32'(bus_rdata), 32'h0);

    // R2 R3 R4: sweep every select code
    for (int s = 0; s < 256; s++) begin
      do_sel(8'(s));
      do_conf(8'(s) ^ 8'hA5);
      if (sel_pin(8'(s)) >= 0) begin
        chk("R2 cfg readback", 32'(cfg_rdata), 32'(exp_cfg_rd()));
        chk("R3 upper zero", 32'(cfg_rdata[7:3]), 32'h0);
      end else begin
        chk("R4 invalid reads zero", 32'(cfg_rdata), 32'h0);
        chk_pads("R4 invalid no write");
      end
    end

    // R5: select and config strobes together
    set_pin_cfg(3, 3'b000);
    set_pin_cfg(13, 3'b010);
    do_sel(8'h03);
    cfg_sel_wr = 1'b1; cfg_conf_wr = 1'b1; cfg_wdata = 8'h15;
    @(negedge clk);
    cfg_sel_wr = 1'b0; cfg_conf_wr = 1'b0;
    m_cfg[3] = 3'b101; m_sel = 8'h15;
    chk("R5 new select active", 32'(cfg_rdata), 32'h02);
    do_sel(8'h03);
    chk("R5 old pin written", 32'(cfg_rdata), 32'h05);
    chk_pads("R5");

    // R9 R7: every pin through all settings and both latch values
    for (int p = 0; p < NP; p++)
      for (int c = 0; c < 8; c++) begin
        set_pin_cfg(p, 3'(c));
        for (int v = 0; v < 2; v++) begin
          logic [3:0] a;
          logic [7:0] d;
          a = (p < 24) ? 4'((p / 8) * 4) : 4'hA;
          d = '0;
          for (int j = 0; j < 8; j++)
            if ((p / 8) * 8 + j < NP) d[j] = m_out[(p/8)*8+j];
          d[p % 8] = 1'(v);
          do_bwr(a, d);
          chk_pads("R9 R7 pad drive");
        end
      end

    // R6 R8 R10: read all addresses under several pin patterns and settings
    for (int k = 0; k < 4; k++) begin
      for (int p = 0; p < NP; p++) set_pin_cfg(p, 3'((p * 3 + k) % 8));
      do_bwr(4'h0, 8'(8'h3C ^ k)); do_bwr(4'h4, 8'hC5);
      do_bwr(4'h8, 8'h5A);         do_bwr(4'hA, 8'hFF);
      pad_in = pats[k];
      for (int a = 0; a < 16; a++) begin
        do_brd(4'(a), got);
        chk((port_of(4'(a)) < 0) ? "R6 unmapped read" : "R8 port read",
            32'(got), 32'(exp_bus_rd(4'(a))));
      end
      do_brd(4'hA, got);
      chk("R10 port3 upper zero", 32'(got[7:5]), 32'h0);
    end

    // R6: unmapped writes change nothing
    for (int a = 0; a < 16; a++)
      if (port_of(4'(a)) < 0) begin
        do_bwr(4'(a), 8'hFF);
        chk_pads("R6 unmapped write");
      end

    // R11: read data holds without a strobe
    do_brd(4'h0, held);
    pad_in = ~pad_in;
    do_bwr(4'h0, ~held);
    repeat (3) @(negedge clk);
    chk("R11 rdata hold", 32'(bus_rdata), 32'(held));
    do_brd(4'h0, got);
    chk("R11 rdata update", 32'(got), 32'(exp_bus_rd(4'h0)));

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule